// File: doc/BRIEF.md
# SD Command Path Controller

This block drives the command line of an SD-style card interface. On request it loads a 48-bit command frame and sends it one bit per card bit-clock tick, most significant bit first, with the line output enable held high. When the frame is finished it goes back to idle. If the command control word asks for a completion handshake, it instead releases the line and waits for the card to pull the line low.

After the card signals completion, the block holds off any new command for a fixed recovery window. During the first part of that window the line stays released. During the rest it drives the line actively high. Completion also sets a sticky status flag, which software clears by writing a one to the matching bit of an acknowledge word. Each interrupt line reports the flag when its own mask word enables that bit.

Clearing the path enable drops the machine straight back to idle. This aborts a pending wait without recording a completion. All registers run on the system clock, and the sequence advances only on cycles where the bit-clock enable is high.

Top module: `cmdp_ctrl`

## Requirements
- R1: A start request accepted in idle loads `cmd_word`. Bit 47 appears on `cmd_out` first, and the frame then moves one bit lower per enabled cycle. `cmd_oe` and `busy` are high for exactly 48 enabled cycles.
- R2: After the 48th bit, when bits 12 and 13 of `cmd_ctrl` (sampled at the start) are not both 1, the machine returns to idle: `busy` is low and `cmd_oe` is low.
- R3: After the 48th bit, when bits 12 and 13 of `cmd_ctrl` are both 1, the machine enters a wait state. In that state `cmd_oe` is low and `busy` is high until a 0 is sampled on `cmd_in`.
- R4: A 0 sampled on `cmd_in` during the wait starts a recovery window of 7 enabled cycles. `busy` stays high throughout the window and falls after it.
- R5: In the first 2 recovery cycles `cmd_oe` is low. In the last 5, `cmd_oe` and `cmd_out` are both high.
- R6: A start request is ignored whenever the machine is not idle, including during the recovery window.
- R7: Completion sets `cpl_flag`. The flag stays set until a cycle with `ack_wr` high and bit 23 of `ack_data` set. An acknowledge write with bit 23 clear has no effect.
- R8: `irq[i]` is high exactly when `cpl_flag` is high and bit 23 of mask word i is set. Mask word i is `irq_mask[32*i+31:32*i]`.
- R9: When `path_en` is low, the machine is idle after the next clock regardless of `bit_en`, and start requests are ignored. A completion level on `cmd_in` at that same edge does not set `cpl_flag`.
- R10: On cycles where `bit_en` is low, the sequence does not advance: the frame bit, the wait state and the recovery window all hold.
- R11: While and right after reset, `busy`, `cmd_oe`, `cpl_flag` and every `irq` bit are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Card bit-clock enable; the sequence advances only when high |
| path_en | input | 1 | Command path enable; low forces idle |
| cmd_start | input | 1 | Start request, accepted in idle on an enabled cycle |
| cmd_word | input | 48 | Command frame to send |
| cmd_ctrl | input | 32 | Command control word; bits 12 and 13 request the completion wait |
| cmd_in | input | 1 | Sampled level of the CMD line |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_data | input | 32 | Acknowledge word; bit 23 clears the completion flag |
| irq_mask | input | 64 | Mask words, one 32-bit word per interrupt line |
| cmd_out | output | 1 | CMD line output level |
| cmd_oe | output | 1 | CMD line output enable |
| busy | output | 1 | High whenever the machine is not idle |
| cpl_flag | output | 1 | Sticky completion status |
| irq | output | 2 | Interrupt lines |

## Verification
The line outputs and `busy` follow the state register. They therefore show the effect of an enabled edge one clock later: frame bit k appears after the k-th enabled edge that follows acceptance. The recovery window spans the 7 edges after the one that sampled the completion level, and `cpl_flag` and `irq` rise together with entry into that window. The driver applies inputs just after each rising edge and pushes the state expected after that edge into a queue. A monitor pops and compares one entry at the following falling edge, so every comparison lands exactly one register stage after its stimulus. Acknowledge writes are checked directly at the falling edge after the edge that applies them.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2,
      ST_LOCK = 2'd3
   } cmdp_state_t;

endpackage

// File: rtl/cmdp_serializer.sv
module cmdp_serializer #(
   parameter int FRAME_W   = 48,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               shift,
   input  logic [FRAME_W-1:0] word,
   output logic               bit_o,
   output logic               last
);
   localparam int CW = $clog2(FRAME_W);

   logic [FRAME_W-1:0] shreg;
   logic [CW-1:0]      cnt;

   // bit counter
   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= '0;
      else if (shift && !last) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CW'(FRAME_W - 1));

   // direction variant picked at elaboration
   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n)     shreg <= '0;
            else if (load)  shreg <= word;
            else if (shift) shreg <= {shreg[FRAME_W-2:0], 1'b0};
         end
         assign bit_o = shreg[FRAME_W-1];
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n)     shreg <= '0;
            else if (load)  shreg <= word;
            else if (shift) shreg <= {1'b0, shreg[FRAME_W-1:1]};
         end
         assign bit_o = shreg[0];
      end
   endgenerate

endmodule

// File: rtl/cmdp_recovery.sv
module cmdp_recovery #(
   parameter int LOCK_CYC = 7,
   parameter int LOCK_REL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic step,
   output logic drive_hi,
   output logic done
);
   localparam int LW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;

   logic [LW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (arm)            cnt <= '0;
      else if (step && !done)  cnt <= cnt + 1'b1;
   end

   assign done     = (cnt == LW'(LOCK_CYC - 1));
   assign drive_hi = (cnt >= LW'(LOCK_REL));

endmodule

// File: rtl/cmdp_status.sv
module cmdp_status #(
   parameter int REG_W   = 32,
   parameter int CPL_BIT = 23,
   parameter int NLINES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    set,
   input  logic                    ack_wr,
   input  logic [REG_W-1:0]        ack_data,
   input  logic [NLINES*REG_W-1:0] mask_flat,
   output logic                    flag,
   output logic [NLINES-1:0]       irq
);
   logic unused_bits;
   assign unused_bits = ^{ack_data, mask_flat};

   // set has priority over an acknowledge in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)                             flag <= 1'b0;
      else if (set)                           flag <= 1'b1;
      else if (ack_wr && ack_data[CPL_BIT])   flag <= 1'b0;
   end

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         assign irq[i] = flag & mask_flat[i*REG_W + CPL_BIT];
      end
   endgenerate

endmodule

// File: rtl/cmdp_ctrl.sv
module cmdp_ctrl
   import cmdp_pkg::*;
#(
   parameter int FRAME_W   = 48,
   parameter int REG_W     = 32,
   parameter int CPLEN_BIT = 12,
   parameter int NIEN_BIT  = 13,
   parameter int CPL_BIT   = 23,
   parameter int NLINES    = 2,
   parameter int LOCK_CYC  = 7,
   parameter int LOCK_REL  = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bit_en,
   input  logic                    path_en,
   input  logic                    cmd_start,
   input  logic [FRAME_W-1:0]      cmd_word,
   input  logic [REG_W-1:0]        cmd_ctrl,
   input  logic                    cmd_in,
   input  logic                    ack_wr,
   input  logic [REG_W-1:0]        ack_data,
   input  logic [NLINES*REG_W-1:0] irq_mask,
   output logic                    cmd_out,
   output logic                    cmd_oe,
   output logic                    busy,
   output logic                    cpl_flag,
   output logic [NLINES-1:0]       irq
);
   // elaboration-time parameter checks
   generate
      if (FRAME_W < 2)          begin : g_chk_fw  $error("FRAME_W must be at least 2"); end
      if (LOCK_REL >= LOCK_CYC) begin : g_chk_lk  $error("LOCK_REL must be below LOCK_CYC"); end
      if (CPL_BIT >= REG_W)     begin : g_chk_cb  $error("CPL_BIT out of range"); end
      if (CPLEN_BIT >= REG_W || NIEN_BIT >= REG_W)
                                begin : g_chk_ctl $error("control bit out of range"); end
      if (NLINES < 1)           begin : g_chk_nl  $error("NLINES must be at least 1"); end
   endgenerate

   cmdp_state_t st, st_nxt;
   logic        wait_q;
   logic        accept, shift, cpl_hit, step;
   logic        ser_bit, ser_last, lock_hi, lock_done;
   logic        unused_ctrl;

   assign unused_ctrl = ^cmd_ctrl;

   assign accept  = path_en && bit_en && (st == ST_IDLE) && cmd_start;
   assign shift   = path_en && bit_en && (st == ST_SEND);
   assign cpl_hit = path_en && bit_en && (st == ST_WAIT) && !cmd_in;
   assign step    = path_en && bit_en && (st == ST_LOCK);

   always_comb begin
      st_nxt = st;
      if (!path_en) begin
         st_nxt = ST_IDLE;
      end else if (bit_en) begin
         case (st)
            ST_IDLE: if (cmd_start) st_nxt = ST_SEND;
            ST_SEND: if (ser_last)  st_nxt = wait_q ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (!cmd_in)   st_nxt = ST_LOCK;
            ST_LOCK: if (lock_done) st_nxt = ST_IDLE;
            default:                st_nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         wait_q <= 1'b0;
      end else begin
         st <= st_nxt;
         if (accept) wait_q <= cmd_ctrl[CPLEN_BIT] & cmd_ctrl[NIEN_BIT];
      end
   end

   cmdp_serializer #(
      .FRAME_W   (FRAME_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .shift (shift),
      .word  (cmd_word),
      .bit_o (ser_bit),
      .last  (ser_last)
   );

   cmdp_recovery #(
      .LOCK_CYC (LOCK_CYC),
      .LOCK_REL (LOCK_REL)
   ) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (cpl_hit),
      .step     (step),
      .drive_hi (lock_hi),
      .done     (lock_done)
   );

   cmdp_status #(
      .REG_W   (REG_W),
      .CPL_BIT (CPL_BIT),
      .NLINES  (NLINES)
   ) u_sts (
      .clk       (clk),
      .rst_n     (rst_n),
      .set       (cpl_hit),
      .ack_wr    (ack_wr),
      .ack_data  (ack_data),
      .mask_flat (irq_mask),
      .flag      (cpl_flag),
      .irq       (irq)
   );

   assign cmd_oe  = (st == ST_SEND) || ((st == ST_LOCK) && lock_hi);
   assign cmd_out = (st == ST_SEND) ? ser_bit : 1'b1;
   assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/cmdp_ctrl_chk.sv
module cmdp_ctrl_chk
   import cmdp_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int CPL_BIT = 23,
   parameter int NLINES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              path_en,
   input logic              ack_wr,
   input logic [REG_W-1:0]  ack_data,
   input logic              cmd_out,
   input logic              cmd_oe,
   input logic              busy,
   input logic              cpl_flag,
   input logic [NLINES-1:0] irq,
   input cmdp_state_t       st
);

   assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !path_en |=> (st == ST_IDLE));

   assert_hold_when_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && !bit_en) |=> $stable(st));

   assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_flag && !(ack_wr && ack_data[CPL_BIT])) |=> cpl_flag);

   assert_no_irq_without_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpl_flag |-> (irq == '0));

   assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (path_en && st != ST_IDLE && st != ST_SEND) |=> (st != ST_SEND));

   assert_flag_enters_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpl_flag) |-> (st == ST_LOCK && !cmd_oe));

   assert_lock_exit_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(st) == ST_LOCK) |-> ($past(cmd_oe) && $past(cmd_out)));

   assert_wait_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> (!cmd_oe && busy));

endmodule

bind cmdp_ctrl cmdp_ctrl_chk #(
   .REG_W   (REG_W),
   .CPL_BIT (CPL_BIT),
   .NLINES  (NLINES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .path_en  (path_en),
   .ack_wr   (ack_wr),
   .ack_data (ack_data),
   .cmd_out  (cmd_out),
   .cmd_oe   (cmd_oe),
   .busy     (busy),
   .cpl_flag (cpl_flag),
   .irq      (irq),
   .st       (st)
);

// File: tb/cmdp_ctrl_test.sv
module cmdp_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 48;
   localparam int RW = 32;
   localparam int NL = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, path_en = 1'b0, cmd_start = 1'b0, cmd_in = 1'b1, ack_wr = 1'b0;
   logic [FW-1:0]    cmd_word = '0;
   logic [RW-1:0]    cmd_ctrl = '0, ack_data = '0;
   logic [NL*RW-1:0] irq_mask = {32'hFF7F_FFFF, 32'h0080_0000};
   logic cmd_out, cmd_oe, busy, cpl_flag;
   logic [NL-1:0] irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmdp_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .path_en(path_en),
      .cmd_start(cmd_start), .cmd_word(cmd_word), .cmd_ctrl(cmd_ctrl),
      .cmd_in(cmd_in), .ack_wr(ack_wr), .ack_data(ack_data), .irq_mask(irq_mask),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .cpl_flag(cpl_flag), .irq(irq)
   );

   int total = 0, bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [5:0] v;   // {out, oe, busy, flag, irq[1:0]}
      int         tag;
   } exp_t;
   exp_t q[$];

   // reference state derived from the requirements
   int ph = 0, bidx = 0, lcnt = 0;
   bit wq = 1'b0, mflag = 1'b0;
   logic [FW-1:0] mword = '0;

   function automatic string tname(int t);
      case (t)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   5: return "R5";   6: return "R6";
         7: return "R7";   8: return "R8";   9: return "R9";
         10: return "R10"; default: return "R11";
      endcase
   endfunction

   task automatic check(int t, logic [5:0] act, logic [5:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tname(t), act, exp, $time);
      end
   endtask

   // monitor: one expected item per falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         check(it.tag, {cmd_out, cmd_oe, busy, cpl_flag, irq}, it.v);
      end
   end

   task automatic model_edge();
      if (!path_en) ph = 0;
      else if (bit_en) begin
         case (ph)
            0: if (cmd_start) begin
                  ph = 1; bidx = 0; mword = cmd_word;
                  wq = cmd_ctrl[12] & cmd_ctrl[13];
               end
            1: if (bidx == FW-1) ph = wq ? 2 : 0; else bidx++;
            2: if (!cmd_in) begin ph = 3; lcnt = 0; mflag = 1'b1; end
            default: if (lcnt == 6) ph = 0; else lcnt++;
         endcase
      end
   endtask

   task automatic push_exp(int scn_tag, int c, int restart_edge);
      exp_t it;
      logic o, oe;
      int t;
      o  = (ph == 1) ? mword[FW-1-bidx] : 1'b1;
      oe = (ph == 1) || (ph == 3 && lcnt >= 2);
      case (ph)
         1: t = 1;
         2: t = 3;
         3: t = (lcnt >= 2) ? 5 : 4;
         default: t = 2;
      endcase
      if (scn_tag != 0) t = scn_tag;
      else if (restart_edge != 0 && c >= restart_edge) t = 6;
      it.v   = {o, oe, (ph != 0), mflag, 1'b0, mflag};
      it.tag = t;
      q.push_back(it);
   endtask

   // driver: inputs change just after a rising edge
   task automatic run_cmd(input logic [FW-1:0] w, input logic [RW-1:0] ctrl,
                          input int ncyc, input int en_mode, input int cpl_edge,
                          input int abort_edge, input int restart_edge, input int scn_tag);
      for (int c = 0; c <= ncyc; c++) begin
         int e;
         @(posedge clk); #1;
         if (c > 0) model_edge();
         push_exp(scn_tag, c, restart_edge);
         e = c + 1;
         cmd_word  = w;
         cmd_ctrl  = ctrl;
         cmd_start = (e == 1) || (e == restart_edge);
         bit_en    = (en_mode == 0) ? 1'b1 : ((e % 2) == 1);
         cmd_in    = (cpl_edge != 0 && e >= cpl_edge) ? 1'b0 : 1'b1;
         path_en   = (abort_edge != 0 && e >= abort_edge) ? 1'b0 : 1'b1;
      end
      @(posedge clk); #1;
      model_edge();
      cmd_start = 1'b0; bit_en = 1'b1; path_en = 1'b1; cmd_in = 1'b1;
      while (q.size() > 0) @(negedge clk);
      #1;
   endtask

   task automatic ack_write(input logic [RW-1:0] d);
      @(posedge clk); #1;
      ack_wr = 1'b1; ack_data = d;
      @(posedge clk); #1;
      ack_wr = 1'b0; ack_data = '0;
      @(negedge clk);
   endtask

   initial begin
      // R11: reset state
      path_en = 1'b1; bit_en = 1'b1; cmd_start = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(11, {cmd_oe, busy, cpl_flag, irq}, 5'b0);
      @(posedge clk); #1;
      rst_n = 1'b1; cmd_start = 1'b0;
      @(negedge clk);
      check(11, {cmd_oe, busy, cpl_flag, irq}, 5'b0);

      // R1/R2: plain frame, no wait requested
      run_cmd(48'hA5C3_0F1E_9B27, 32'h0, 52, 0, 0, 0, 0, 0);
      // R2: only the completion-enable bit set, still no wait
      run_cmd(48'h8000_0000_0001, 32'h0000_1000, 52, 0, 0, 0, 0, 0);
      // R3/R4/R5/R6/R7/R8: wait, completion at edge 55, restart attempt inside the recovery window
      run_cmd(48'h3C69_F00D_5AA5, 32'h0000_3000, 66, 0, 55, 0, 58, 0);

      // R7: acknowledge without bit 23 leaves the flag set
      ack_write(~(32'h1 << 23));
      check(7, {cpl_flag, irq}, 3'b101);
      // R7/R8: acknowledge with bit 23 clears flag and interrupts
      ack_write(32'h1 << 23);
      mflag = 1'b0;
      check(8, {cpl_flag, irq}, 3'b000);

      // R9: disable during wait together with completion level, then start while disabled
      run_cmd(48'h1234_5678_9ABC, 32'h0000_3000, 66, 0, 60, 60, 62, 9);
      check(9, {cpl_flag, busy}, 2'b00);

      // R10: bit enable high only every other cycle
      run_cmd(48'hF0E1_D2C3_B4A5, 32'h0, 100, 1, 0, 0, 0, 10);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule